// File: doc/BRIEF.md
# Row-Hit-First Request Scheduler for One Memory Bank

This block queues pending accesses for a single memory bank and picks the next one to service. Each queued access carries a row address, a column address and a read/write flag. The position of an entry in the queue records its arrival order. The bank reports whether a row is open and which one. From the queue contents and that row state, the block selects a request every cycle through combinational logic.

In the default policy, requests whose row matches the open row are served first, because they need only a column command. Requests that need an activate or precharge wait behind them. Arrival order breaks ties inside each of the two groups. A mode input switches the block to strict oldest-first order.

A request leaves the queue when the bank signals that it can accept one. The remaining entries close up over the vacated slot and keep their relative order. An upstream agent fills the queue through a valid/ready port. One push and one removal may occur in the same cycle.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty: `sel_valid` is 0, `deq` is 0 and `enq_ready` is 1.
- R2: `enq_ready` is 0 exactly when DEPTH requests are held. An `enq_valid` offered while `enq_ready` is 0 is ignored and adds no entry.
- R3: With `fcfs_mode` = 1, the selected request is always the oldest pending one, whatever the open row.
- R4: With `fcfs_mode` = 0 and `open_valid` = 1, a request whose row equals `open_row` is selected over every request whose row differs, even when those are older.
- R5: With `fcfs_mode` = 0 and `open_valid` = 1, when several pending requests hit the open row, the oldest of them is selected.
- R6: With `fcfs_mode` = 0 and `open_valid` = 1, when no pending request hits the open row, the oldest pending request is selected.
- R7: With `open_valid` = 0, every request counts as a miss and the oldest pending request is selected.
- R8: `deq` is high in the same cycle that `sel_valid` and `bank_ready` are both high. The shown request is then removed at that clock edge. No request is removed while `bank_ready` is 0.
- R9: An enqueue and a dequeue may happen in the same cycle. The remaining entries keep their arrival order, and the new request becomes the youngest.
- R10: `sel_row`, `sel_col` and `sel_wr` carry the row, column and write flag that were enqueued with the selected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 selects strict oldest-first; 0 selects row-hit-first |
| open_valid | input | 1 | A row is open in the bank |
| open_row | input | ROW_W | Row currently held open |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Queue can accept a request |
| enq_row | input | ROW_W | Row of the offered request |
| enq_col | input | COL_W | Column of the offered request |
| enq_wr | input | 1 | 1 for write, 0 for read |
| bank_ready | input | 1 | Bank accepts the selected request this cycle |
| sel_valid | output | 1 | A request is selected |
| sel_row | output | ROW_W | Row of the selected request |
| sel_col | output | COL_W | Column of the selected request |
| sel_wr | output | 1 | Write flag of the selected request |
| deq | output | 1 | Strobe: the selected request is taken this cycle |

## Verification
Selection, `deq` and `enq_ready` are combinational from the queue state and the current inputs. They are due in the same cycle the inputs are applied. An accepted push or a dequeue shows up in the outputs one clock edge later. The bench changes inputs just after the falling edge and compares all outputs one nanosecond later. It updates its own arrival-ordered model of the queue at the following rising edge. As a result, every comparison covers the state left by the previous edge combined with the inputs of the current cycle.

// File: rtl/frfcfs_sched.sv
module frfcfs_sched #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fcfs_mode,
  input  logic             open_valid,
  input  logic [ROW_W-1:0] open_row,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [COL_W-1:0] enq_col,
  input  logic             enq_wr,
  input  logic             bank_ready,
  output logic             sel_valid,
  output logic [ROW_W-1:0] sel_row,
  output logic [COL_W-1:0] sel_col,
  output logic             sel_wr,
  output logic             deq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // slot 0 holds the oldest request; slots at or above count are empty
  logic [ROW_W-1:0] q_row [DEPTH];
  logic [COL_W-1:0] q_col [DEPTH];
  logic             q_wr  [DEPTH];
  logic [CW-1:0]    count;
  logic [IW-1:0]    sel_idx;
  logic [IW-1:0]    wpos;
  logic             hit_found;
  logic             push;

  always_comb begin
    hit_found = 1'b0;
    sel_idx   = '0;
    if (!fcfs_mode && open_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!hit_found && i < int'(count) && q_row[i] == open_row) begin
          hit_found = 1'b1;
          sel_idx   = IW'(i);
        end
      end
    end
  end

  assign sel_valid = (count != '0);
  assign sel_row   = q_row[sel_idx];
  assign sel_col   = q_col[sel_idx];
  assign sel_wr    = q_wr[sel_idx];
  assign deq       = sel_valid && bank_ready;
  assign enq_ready = (int'(count) < DEPTH);
  assign push      = enq_valid && enq_ready;
  assign wpos      = IW'(count - CW'(deq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count + CW'(push) - CW'(deq);
    end
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (deq && i >= int'(sel_idx)) begin
        q_row[i] <= q_row[i+1];
        q_col[i] <= q_col[i+1];
        q_wr[i]  <= q_wr[i+1];
      end
    end
    if (push) begin
      q_row[wpos] <= enq_row;
      q_col[wpos] <= enq_col;
      q_wr[wpos]  <= enq_wr;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  assert_full_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready |-> sel_valid);
  assert_oldest_in_fcfs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fcfs_mode && sel_valid) |-> (sel_idx == '0));
  assert_closed_row_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_valid && sel_valid) |-> (sel_idx == '0));
  assert_head_hit_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fcfs_mode && open_valid && sel_valid && q_row[0] == open_row) |-> (sel_idx == '0));
  assert_deq_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !push) |=> (count == $past(count) - CW'(1)));
  assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !deq) |=> (count == $past(count) + CW'(1)));
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_ready && !push) |=> $stable(count));
endmodule

// File: tb/tb_frfcfs_sched.sv
`timescale 1ns/1ps
module tb_frfcfs_sched;
  localparam int N  = 4;
  localparam int RW = 3;
  localparam int CWD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcfs_mode = 1'b0, open_valid = 1'b0, enq_valid = 1'b0, enq_wr = 1'b0, bank_ready = 1'b0;
  logic [RW-1:0] open_row = '0, enq_row = '0;
  logic [CWD-1:0] enq_col = '0;
  logic enq_ready, sel_valid, sel_wr, deq;
  logic [RW-1:0] sel_row;
  logic [CWD-1:0] sel_col;

  always #2 clk = ~clk;

  frfcfs_sched #(.DEPTH(N), .ROW_W(RW), .COL_W(CWD)) dut (
    .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode), .open_valid(open_valid),
    .open_row(open_row), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_row(enq_row), .enq_col(enq_col), .enq_wr(enq_wr), .bank_ready(bank_ready),
    .sel_valid(sel_valid), .sel_row(sel_row), .sel_col(sel_col), .sel_wr(sel_wr), .deq(deq));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_row [N];
  int m_col [N];
  int m_wr  [N];
  int mcnt = 0;
  int seq = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit fm, input bit ov, input int orow, input bit br,
                      input bit ev, input int erow);
    int idx; bit hit; bit e_valid; bit e_deq; bit e_push; string tag;
    @(negedge clk);
    fcfs_mode = fm; open_valid = ov; open_row = RW'(orow); bank_ready = br;
    enq_valid = ev; enq_row = RW'(erow); enq_col = CWD'(seq); enq_wr = seq[2];
    #1;
    idx = 0; hit = 0;
    if (!fm && ov)
      for (int i = 0; i < mcnt; i++)
        if (!hit && m_row[i] == orow) begin hit = 1; idx = i; end
    if (fm) tag = "R3 oldest in fcfs mode";
    else if (!ov) tag = "R7 closed row oldest";
    else if (hit && idx > 0) tag = "R4 hit beats older miss";
    else if (hit) tag = "R5 oldest hit";
    else tag = "R6 no hit oldest";
    e_valid = (mcnt > 0);
    chk(sel_valid == e_valid, "R1 sel_valid vs occupancy", int'(sel_valid), int'(e_valid));
    chk(enq_ready == (mcnt < N), "R2 enq_ready vs full", int'(enq_ready), int'(mcnt < N));
    e_deq = e_valid && br;
    chk(deq == e_deq, "R8 deq strobe", int'(deq), int'(e_deq));
    if (e_valid && sel_valid) begin
      chk(int'(sel_col) == m_col[idx], tag, int'(sel_col), m_col[idx]);
      chk(int'(sel_row) == m_row[idx], "R10 selected row", int'(sel_row), m_row[idx]);
      chk(int'(sel_wr) == m_wr[idx], "R10 selected write flag", int'(sel_wr), m_wr[idx]);
    end
    e_push = ev && (mcnt < N);
    @(posedge clk);
    if (e_deq) begin
      for (int i = idx; i < mcnt - 1; i++) begin
        m_row[i] = m_row[i+1]; m_col[i] = m_col[i+1]; m_wr[i] = m_wr[i+1];
      end
      mcnt--;
    end
    if (e_push) begin
      m_row[mcnt] = erow; m_col[mcnt] = seq % (1 << CWD); m_wr[mcnt] = (seq >> 2) & 1;
      mcnt++;
      seq++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sel_valid == 1'b0, "R1 reset sel_valid", int'(sel_valid), 0);
    chk(enq_ready == 1'b1, "R1 reset enq_ready", int'(enq_ready), 1);
    chk(deq == 1'b0, "R1 reset deq", int'(deq), 0);
    rst_n = 1'b1;
    // R2: fill to full while the bank stalls, then keep offering
    for (int k = 0; k < 7; k++) step(0, 1, 2, 0, 1, k % 3);
    // R4 R5: drain with row 2 open; hits leave first
    for (int k = 0; k < 5; k++) step(0, 1, 2, 1, 0, 0);
    // R9: simultaneous push and pop
    for (int k = 0; k < 6; k++) step(0, 1, 1, 1, 1, k % 2);
    for (int ph = 0; ph < 4; ph++) begin
      for (int t = 0; t < 3000; t++) begin
        int orow;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        orow = (ph == 3) ? 7 : int'(lf[7:6]);
        step(ph == 1, ph != 2 && (lf[9] | lf[8]), orow,
             lf[2] & (lf[3] | (ph == 0)), lf[0] | lf[1], int'(lf[5:4]));
      end
    end
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule